// File: doc/BRIEF.md
# Register-List Stack Save/Restore Sequencer

This block moves a group of registers to and from a downward-growing stack, one register per clock cycle. A command carries an 8-bit selection mask, a direction (save or restore), an operand width (16-bit word or 8-bit byte), a bank select, and the stack pointer to start from. Bit k of the mask names register k of the lower bank, or register k+8 when the bank select is set. The sequencer visits only the set bits. For each one it issues a register-file read and a memory write, or a memory read and a register-file write. It then reports the final stack pointer and raises a one-cycle completion strobe.

A save walks the mask from the most significant bit down to bit 0. Before each store it moves the pointer down by one 2-byte slot. A restore walks from bit 0 upward. It reads at the current pointer and then moves the pointer up by one slot. As a result, a restore with the same mask undoes a save. Byte registers still take a full 2-byte slot. Register-file and memory read data are expected back combinationally in the same cycle as the request. Memory arbitration and instruction decode stay outside the block.

Top module: `regmask_stacker`

## Requirements
- R1: The register index driven on `rf_idx_o` is the mask bit position k in its low 3 bits, and the latched bank select in bit 3, which gives k or k+8.
- R2: A save visits set mask bits from 7 down to 0. Each store goes to the address two below the previous pointer, and that address becomes the new pointer.
- R3: A restore visits set mask bits from 0 up to 7. Each load reads at the current pointer, and the pointer then advances by two.
- R4: When `done_o` is high, `sp_o` equals the starting pointer minus 2·N for a save, or plus 2·N for a restore, where N is the number of set mask bits. Arithmetic wraps modulo 2^16.
- R5: A byte save writes a 16-bit slot holding the register's low 8 bits in bits 7:0 and zero in bits 15:8.
- R6: A byte restore drives `rf_word_o` low and `rf_wdata_o` as the loaded word's bits 7:0 in bits 7:0, with zero above. A word restore drives `rf_word_o` high with the full loaded word.
- R7: Only one of the two directions is active in a cycle. Cleared mask bits take no cycle, so N set bits take exactly N busy cycles with one memory access each.
- R8: An empty mask performs no access. It raises `done_o` in the first cycle after the start edge, with `sp_o` equal to the starting pointer.
- R9: `start_i` is ignored while `busy_o` is high. The running command's accesses, mode and final pointer are unaffected.
- R10: `done_o` is high for exactly one cycle. That cycle is the one after the last access, which is cycle N+1 counted from the start edge, and `busy_o` is low in it.
- R11: After reset, `busy_o`, `done_o` and all request outputs are low, and `sp_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Command strobe, sampled while idle |
| pop_i | input | 1 | 1 = restore from stack, 0 = save to stack |
| word_i | input | 1 | 1 = 16-bit registers, 0 = 8-bit registers |
| hi_bank_i | input | 1 | Selects registers 8..15 instead of 0..7 |
| mask_i | input | 8 | Register selection mask |
| sp_i | input | 16 | Starting stack pointer |
| rf_rd_o | output | 1 | Register-file read request (save) |
| rf_wr_o | output | 1 | Register-file write request (restore) |
| rf_idx_o | output | 4 | Register index |
| rf_word_o | output | 1 | Width of the register access |
| rf_wdata_o | output | 16 | Register-file write data |
| rf_rdata_i | input | 16 | Register-file read data, same cycle |
| mem_wr_o | output | 1 | Memory write request |
| mem_rd_o | output | 1 | Memory read request |
| mem_addr_o | output | 16 | Memory slot address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, same cycle |
| busy_o | output | 1 | Command in progress |
| sp_o | output | 16 | Current and, at done, final stack pointer |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
The first memory access of a command appears in the cycle right after the start edge. The k-th access appears k cycles after that edge, and `done_o` with the final `sp_o` appears at cycle N+1, or at cycle 1 for an empty mask. The bench drives each input on a falling edge and then counts falling edges until `done_o`, comparing that count with N+1. A separate monitor takes every access on the falling edge and matches it in order against a queue of expected address, index, data and width. That queue is filled before the command starts, so ordering, skipping of cleared bits and data shaping are all compared access by access.

// File: rtl/regstk_pkg.sv
package regstk_pkg;
   localparam int unsigned SLOT_BYTES = 2;
   localparam int unsigned BYTE_W     = 8;

   typedef enum logic {
      DIR_SAVE    = 1'b0,
      DIR_RESTORE = 1'b1
   } stk_dir_e;
endpackage

// File: rtl/regstk_mask_picker.sv
module regstk_mask_picker #(
   parameter int unsigned W          = 8,
   parameter bit          HIGH_FIRST = 1'b1,
   localparam int unsigned IW        = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  vec,
   output logic [IW-1:0] pos
);
   generate
      if (HIGH_FIRST) begin : g_high
         always_comb begin
            pos = '0;
            for (int i = 0; i < W; i++) begin
               if (vec[i]) pos = IW'(i);
            end
         end
      end else begin : g_low
         always_comb begin
            pos = '0;
            for (int i = W - 1; i >= 0; i--) begin
               if (vec[i]) pos = IW'(i);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/regstk_sp_stepper.sv
module regstk_sp_stepper #(
   parameter int unsigned AW   = 16,
   parameter int unsigned STEP = 2
) (
   input  logic [AW-1:0] sp,
   input  logic          upward,
   output logic [AW-1:0] access_addr,
   output logic [AW-1:0] next_sp
);
   logic [AW-1:0] dec_sp;
   logic [AW-1:0] inc_sp;

   assign dec_sp = sp - AW'(STEP);
   assign inc_sp = sp + AW'(STEP);

   always_comb begin
      if (upward) begin
         access_addr = sp;
         next_sp     = inc_sp;
      end else begin
         access_addr = dec_sp;
         next_sp     = dec_sp;
      end
   end
endmodule

// File: rtl/regstk_slot_shaper.sv
module regstk_slot_shaper #(
   parameter int unsigned DW = 16,
   parameter int unsigned BW = 8
) (
   input  logic          full_width,
   input  logic [DW-1:0] raw,
   output logic [DW-1:0] shaped
);
   generate
      if (DW > BW) begin : g_narrow
         assign shaped = full_width ? raw : {{(DW-BW){1'b0}}, raw[BW-1:0]};
      end else begin : g_same
         assign shaped = raw;
      end
   endgenerate
endmodule

// File: rtl/regmask_stacker.sv
module regmask_stacker #(
   parameter int unsigned MASK_W = 8,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 16,
   localparam int unsigned POS_W = (MASK_W > 1) ? $clog2(MASK_W) : 1,
   localparam int unsigned IDX_W = POS_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              pop_i,
   input  logic              word_i,
   input  logic              hi_bank_i,
   input  logic [MASK_W-1:0] mask_i,
   input  logic [ADDR_W-1:0] sp_i,
   output logic              rf_rd_o,
   output logic              rf_wr_o,
   output logic [IDX_W-1:0]  rf_idx_o,
   output logic              rf_word_o,
   output logic [DATA_W-1:0] rf_wdata_o,
   input  logic [DATA_W-1:0] rf_rdata_i,
   output logic              mem_wr_o,
   output logic              mem_rd_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   input  logic [DATA_W-1:0] mem_rdata_i,
   output logic              busy_o,
   output logic [ADDR_W-1:0] sp_o,
   output logic              done_o
);
   import regstk_pkg::*;

   generate
      if (MASK_W < 2 || (1 << POS_W) != MASK_W) begin : g_bad_mask
         $error("MASK_W must be a power of two of at least 2");
      end
      if (DATA_W < BYTE_W) begin : g_bad_data
         $error("DATA_W must hold at least one byte");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W too small for a 2-byte slot");
      end
   endgenerate

   logic              busy_q;
   logic              done_q;
   stk_dir_e          dir_q;
   logic              word_q;
   logic              hi_q;
   logic [MASK_W-1:0] pend_q;
   logic [ADDR_W-1:0] sp_q;

   logic [POS_W-1:0]  pos_top;
   logic [POS_W-1:0]  pos_bot;
   logic [POS_W-1:0]  pos_sel;
   logic [MASK_W-1:0] pend_next;
   logic [ADDR_W-1:0] acc_addr;
   logic [ADDR_W-1:0] sp_next;
   logic              restoring;

   assign restoring = (dir_q == DIR_RESTORE);

   regstk_mask_picker #(.W(MASK_W), .HIGH_FIRST(1'b1)) u_pick_top (
      .vec (pend_q),
      .pos (pos_top)
   );

   regstk_mask_picker #(.W(MASK_W), .HIGH_FIRST(1'b0)) u_pick_bot (
      .vec (pend_q),
      .pos (pos_bot)
   );

   assign pos_sel   = restoring ? pos_bot : pos_top;
   assign pend_next = pend_q & ~(MASK_W'(1) << pos_sel);

   regstk_sp_stepper #(.AW(ADDR_W), .STEP(SLOT_BYTES)) u_step (
      .sp          (sp_q),
      .upward      (restoring),
      .access_addr (acc_addr),
      .next_sp     (sp_next)
   );

   regstk_slot_shaper #(.DW(DATA_W), .BW(BYTE_W)) u_shape_out (
      .full_width (word_q),
      .raw        (rf_rdata_i),
      .shaped     (mem_wdata_o)
   );

   regstk_slot_shaper #(.DW(DATA_W), .BW(BYTE_W)) u_shape_in (
      .full_width (word_q),
      .raw        (mem_rdata_i),
      .shaped     (rf_wdata_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         dir_q  <= DIR_SAVE;
         word_q <= 1'b0;
         hi_q   <= 1'b0;
         pend_q <= '0;
         sp_q   <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (start_i) begin
               dir_q  <= pop_i ? DIR_RESTORE : DIR_SAVE;
               word_q <= word_i;
               hi_q   <= hi_bank_i;
               sp_q   <= sp_i;
               pend_q <= mask_i;
               if (mask_i == '0) begin
                  done_q <= 1'b1;
               end else begin
                  busy_q <= 1'b1;
               end
            end
         end else begin
            sp_q   <= sp_next;
            pend_q <= pend_next;
            if (pend_next == '0) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign rf_rd_o    = busy_q & ~restoring;
   assign mem_wr_o   = busy_q & ~restoring;
   assign rf_wr_o    = busy_q &  restoring;
   assign mem_rd_o   = busy_q &  restoring;
   assign rf_idx_o   = {hi_q, pos_sel};
   assign rf_word_o  = word_q;
   assign mem_addr_o = acc_addr;
   assign busy_o     = busy_q;
   assign sp_o       = sp_q;
   assign done_o     = done_q;
endmodule

// File: rtl/regstk_checker.sv
module regstk_checker #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned IDX_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              rf_rd_o,
   input logic              rf_wr_o,
   input logic [IDX_W-1:0]  rf_idx_o,
   input logic              rf_word_o,
   input logic [DATA_W-1:0] rf_wdata_o,
   input logic              mem_wr_o,
   input logic              mem_rd_o,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic              busy_o,
   input logic              done_o
);
   localparam int unsigned PW = IDX_W - 1;

   p_one_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_wr_o && mem_rd_o) && !(rf_rd_o && rf_wr_o));

   p_save_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_o && $past(mem_wr_o)) |->
         (mem_addr_o == $past(mem_addr_o) - ADDR_W'(2)) &&
         (rf_idx_o[PW-1:0] < $past(rf_idx_o[PW-1:0])));

   p_restore_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_o && $past(mem_rd_o)) |->
         (mem_addr_o == $past(mem_addr_o) + ADDR_W'(2)) &&
         (rf_idx_o[PW-1:0] > $past(rf_idx_o[PW-1:0])));

   p_byte_restore_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_wr_o && !rf_word_o) |-> (rf_wdata_o[DATA_W-1:8] == '0));

   p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && !mem_wr_o && !mem_rd_o));

   p_end_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);

   p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o) && $past(start_i)) |->
         ($stable(rf_word_o) && $stable(rf_idx_o[IDX_W-1])));
endmodule

bind regmask_stacker regstk_checker #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W),
   .IDX_W  (IDX_W)
) u_regstk_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .rf_rd_o    (rf_rd_o),
   .rf_wr_o    (rf_wr_o),
   .rf_idx_o   (rf_idx_o),
   .rf_word_o  (rf_word_o),
   .rf_wdata_o (rf_wdata_o),
   .mem_wr_o   (mem_wr_o),
   .mem_rd_o   (mem_rd_o),
   .mem_addr_o (mem_addr_o),
   .busy_o     (busy_o),
   .done_o     (done_o)
);

// File: tb/tb_regmask_stacker.sv
module tb_regmask_stacker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        pop_i = 1'b0;
   logic        word_i = 1'b0;
   logic        hi_bank_i = 1'b0;
   logic [7:0]  mask_i = '0;
   logic [15:0] sp_i = '0;
   logic        rf_rd_o, rf_wr_o, rf_word_o, mem_wr_o, mem_rd_o, busy_o, done_o;
   logic [3:0]  rf_idx_o;
   logic [15:0] rf_wdata_o, rf_rdata_i, mem_addr_o, mem_wdata_o, mem_rdata_i, sp_o;

   int n_checks = 0;
   int n_errors = 0;

   typedef struct {
      bit          rd;
      logic [15:0] addr;
      logic [3:0]  idx;
      logic [15:0] data;
      bit          word;
   } acc_t;

   acc_t exp_q[$];

   always #10 clk = ~clk;

   function automatic logic [15:0] rf_model(input logic [3:0] idx);
      return 16'hA000 + 16'(idx) * 16'h0111 + 16'h0009;
   endfunction

   function automatic logic [15:0] mem_model(input logic [15:0] a);
      return a ^ 16'h5AC3;
   endfunction

   assign rf_rdata_i  = rf_model(rf_idx_o);
   assign mem_rdata_i = mem_model(mem_addr_o);

   regmask_stacker dut (
      .clk (clk), .rst_n (rst_n), .start_i (start_i), .pop_i (pop_i),
      .word_i (word_i), .hi_bank_i (hi_bank_i), .mask_i (mask_i), .sp_i (sp_i),
      .rf_rd_o (rf_rd_o), .rf_wr_o (rf_wr_o), .rf_idx_o (rf_idx_o),
      .rf_word_o (rf_word_o), .rf_wdata_o (rf_wdata_o), .rf_rdata_i (rf_rdata_i),
      .mem_wr_o (mem_wr_o), .mem_rd_o (mem_rd_o), .mem_addr_o (mem_addr_o),
      .mem_wdata_o (mem_wdata_o), .mem_rdata_i (mem_rdata_i),
      .busy_o (busy_o), .sp_o (sp_o), .done_o (done_o)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Monitor: every access is matched in order against the scoreboard queue
   always @(negedge clk) begin
      if (rst_n && (mem_wr_o || mem_rd_o)) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R7", "unexpected access addr", 32'(mem_addr_o), 32'hFFFFFFFF);
         end else begin
            acc_t e;
            e = exp_q.pop_front();
            check(mem_rd_o == e.rd && rf_wr_o == e.rd && rf_rd_o == !e.rd && mem_wr_o == !e.rd,
                  "R7", "direction", {mem_rd_o, rf_wr_o, mem_wr_o, rf_rd_o}, 32'(e.rd));
            check(mem_addr_o == e.addr, e.rd ? "R3" : "R2", "slot address",
                  32'(mem_addr_o), 32'(e.addr));
            check(rf_idx_o == e.idx, "R1", "register index", 32'(rf_idx_o), 32'(e.idx));
            if (e.rd) begin
               check(rf_word_o == e.word, "R6", "restore width", 32'(rf_word_o), 32'(e.word));
               check(rf_wdata_o == e.data, "R6", "restore data", 32'(rf_wdata_o), 32'(e.data));
            end else begin
               check(mem_wdata_o == e.data, "R5", "save data", 32'(mem_wdata_o), 32'(e.data));
            end
         end
      end
   end

   // Driver: builds the expected access list, issues the command, times done
   task automatic run_cmd(input bit pop, input bit word, input bit hi,
                          input logic [7:0] mask, input logic [15:0] sp, input bit probe);
      logic [15:0] s = sp;
      int k = 0;
      int n = 0;
      if (!pop) begin
         for (int b = 7; b >= 0; b--) if (mask[b]) begin
            acc_t e;
            s = s - 16'd2;
            e.rd = 1'b0; e.addr = s; e.idx = {hi, 3'(b)}; e.word = word;
            e.data = word ? rf_model(e.idx) : {8'h00, rf_model(e.idx)[7:0]};
            exp_q.push_back(e);
            k++;
         end
      end else begin
         for (int b = 0; b < 8; b++) if (mask[b]) begin
            acc_t e;
            e.rd = 1'b1; e.addr = s; e.idx = {hi, 3'(b)}; e.word = word;
            e.data = word ? mem_model(s) : {8'h00, mem_model(s)[7:0]};
            exp_q.push_back(e);
            s = s + 16'd2;
            k++;
         end
      end
      start_i = 1'b1; pop_i = pop; word_i = word; hi_bank_i = hi;
      mask_i = mask; sp_i = sp;
      @(negedge clk);
      start_i = 1'b0;
      n = 1;
      if (probe) begin
         // R9: a second command while busy, with every field different
         start_i = 1'b1; pop_i = !pop; word_i = !word; hi_bank_i = !hi;
         mask_i = ~mask; sp_i = sp ^ 16'h0F0F;
         check(busy_o == 1'b1, "R9", "busy during command", 32'(busy_o), 32'd1);
      end
      while (!done_o && n < 40) begin
         @(negedge clk);
         start_i = 1'b0;
         n++;
      end
      check(done_o == 1'b1, "R10", "done seen", 32'(done_o), 32'd1);
      check(n == k + 1, k == 0 ? "R8" : "R10", "done cycle", 32'(n), 32'(k + 1));
      check(sp_o == s, k == 0 ? "R8" : "R4", "final pointer", 32'(sp_o), 32'(s));
      check(busy_o == 1'b0, "R10", "idle at done", 32'(busy_o), 32'd0);
      check(exp_q.size() == 0, "R7", "accesses left over", 32'(exp_q.size()), 32'd0);
      exp_q.delete();
      @(negedge clk);
      check(done_o == 1'b0, "R10", "done one cycle", 32'(done_o), 32'd0);
      check(!mem_wr_o && !mem_rd_o, probe ? "R9" : "R10", "no access after done",
            32'({mem_wr_o, mem_rd_o}), 32'd0);
   endtask

   initial begin
      #(20 * 20000);
      check(1'b0, "R7", "watchdog expired", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      check(!busy_o && !done_o && !rf_rd_o && !rf_wr_o && !mem_wr_o && !mem_rd_o,
            "R11", "idle outputs", 32'({busy_o, done_o, rf_rd_o, rf_wr_o, mem_wr_o, mem_rd_o}), 32'd0);
      check(sp_o == 16'h0000, "R11", "pointer at reset", 32'(sp_o), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      run_cmd(1'b0, 1'b1, 1'b0, 8'hA5, 16'h1000, 1'b0); // R2 word save, gaps
      run_cmd(1'b1, 1'b1, 1'b1, 8'h3C, 16'h0F00, 1'b0); // R3 R1 word restore, upper bank
      run_cmd(1'b0, 1'b0, 1'b1, 8'h81, 16'h2000, 1'b0); // R5 byte save, ends of mask
      run_cmd(1'b1, 1'b0, 1'b0, 8'hFF, 16'h3000, 1'b0); // R6 byte restore, full mask
      run_cmd(1'b0, 1'b1, 1'b0, 8'h00, 16'h2222, 1'b0); // R8 empty save
      run_cmd(1'b1, 1'b0, 1'b1, 8'h00, 16'h4444, 1'b0); // R8 empty restore
      run_cmd(1'b0, 1'b1, 1'b1, 8'hFF, 16'h0004, 1'b0); // R4 pointer wrap below zero
      run_cmd(1'b1, 1'b1, 1'b0, 8'hC0, 16'hFFFE, 1'b0); // R4 pointer wrap above top
      run_cmd(1'b0, 1'b1, 1'b0, 8'h0F, 16'h5000, 1'b1); // R9 start while busy
      run_cmd(1'b1, 1'b0, 1'b0, 8'h80, 16'h6000, 1'b0); // R7 single top bit restore
      run_cmd(1'b0, 1'b0, 1'b0, 8'h01, 16'h6000, 1'b0); // R7 single low bit save
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end
endmodule